// File: doc/BRIEF.md
# Timer interrupt flag and mask unit

This block collects the condition pulses of a timer/counter peripheral into sticky status flags and merges them onto one interrupt request line. There are four sources: counter wrap (overflow or underflow), compare/capture channel match, capture-overflow error and synchronization-ready. Each single-cycle pulse sets its own flag. The flag stays set until software clears it by writing a one to it.

An enable mask selects which flags may raise the request. Software changes the mask through two write-one registers. One register only sets enable bits and the other only clears them, so a read-modify-write is never needed. The request output is high while any flag and its enable bit are both set. Software reads the flag register to find which source caused the request.

The wrap pulse and the match pulse are also passed out as event pulses. Each event pulse is gated by its own bit in an event control register. All registers sit on a simple single-cycle register bus. Reads are combinational from the address.

Top module: `tc_irq_unit`

## Requirements
- R1: After reset, all flags, all enable bits and both event enables read as zero, and `irq_o`, `evt_wrap_o` and `evt_match_o` are low.
- R2: A one-cycle pulse on `cond_i[k]` sets flag bit k at the next clock edge, and the flag stays set afterwards. The bit positions are: wrap = 0, match = 1, capture error = 2, sync-ready = 3. The flag register is at address 3.
- R3: Writing address 3 clears every flag whose `wdata_i` bit is one. Flags at zero bits of `wdata_i` keep their value.
- R4: If a condition pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Writing address 2 (enable-set) sets the enable bits at the ones of `wdata_i`. Zero bits leave the enable mask unchanged.
- R6: Writing address 1 (enable-clear) clears the enable bits at the ones of `wdata_i`. Zero bits leave the enable mask unchanged.
- R7: Reading address 1 or address 2 returns the current enable mask in bits 3:0.
- R8: `irq_o` is high exactly while some flag and its enable bit are both set. It stays high until that flag is cleared or that source is disabled.
- R9: A flag sets on its condition whether or not its enable bit is set. Enabling it later raises `irq_o`.
- R10: `evt_wrap_o` equals `cond_i[0]` while event-control bit 0 (address 0) is set, and is low otherwise. `evt_match_o` does the same for `cond_i[1]` with event-control bit 1. Address 0 reads back the event-control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_i | input | 4 | Source condition pulses (wrap, match, capture error, sync-ready) |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt request |
| evt_wrap_o | output | 1 | Gated wrap event pulse |
| evt_match_o | output | 1 | Gated match/capture event pulse |

## Verification
The bench builds the unit with a 4-bit address and an 8-bit data bus, wider than the defaults. This tests that the address decode compares the full address and that read data is zero-extended above the four source bits. It also lets the bench write unused upper data bits, which must have no effect. With this configuration the bench can drive a condition pulse and a clearing write into the same cycle. It can also issue zero-valued set and clear writes against a known mask, and reach the request-persistence cases where only the flag clear or only the mask clear removes the request.

// File: rtl/tc_irq_pkg.sv
package tc_irq_pkg;
  localparam int NUM_SRC  = 4;
  localparam int NUM_EVT  = 2;
  localparam int SRC_WRAP = 0;
  localparam int SRC_MTCH = 1;
  localparam int SRC_CERR = 2;
  localparam int SRC_SYNC = 3;
  localparam int A_EVCTL  = 0;
  localparam int A_ENCLR  = 1;
  localparam int A_ENSET  = 2;
  localparam int A_FLAGS  = 3;
endpackage

// File: rtl/tc_irq_regif.sv
module tc_irq_regif
  import tc_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_EVT-1:0] evctl_i,
  output logic              wr_evctl_o,
  output logic              wr_set_o,
  output logic              wr_clr_o,
  output logic              wr_flag_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_ev, sel_clr, sel_set, sel_flg;

  assign sel_ev  = addr_i == ADDR_W'(A_EVCTL);
  assign sel_clr = addr_i == ADDR_W'(A_ENCLR);
  assign sel_set = addr_i == ADDR_W'(A_ENSET);
  assign sel_flg = addr_i == ADDR_W'(A_FLAGS);

  assign wr_evctl_o = we_i & sel_ev;
  assign wr_set_o   = we_i & sel_set;
  assign wr_clr_o   = we_i & sel_clr;
  assign wr_flag_o  = we_i & sel_flg;

  always_comb begin
    rdata_o = '0;
    if (sel_ev)                rdata_o = DATA_W'(evctl_i);
    else if (sel_clr | sel_set) rdata_o = DATA_W'(mask_i);
    else if (sel_flg)          rdata_o = DATA_W'(flags_i);
  end
endmodule

// File: rtl/tc_irq_flags.sv
module tc_irq_flags
  import tc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] cond_i,
  input  logic               wr_flag_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] flags_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    logic flag_q;
    // a new condition wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q <= 1'b0;
      else if (cond_i[k])   flag_q <= 1'b1;
      else if (wr_flag_i && wdata_i[k]) flag_q <= 1'b0;
    end
    assign flags_o[k] = flag_q;
  end
endmodule

// File: rtl/tc_irq_mask.sv
module tc_irq_mask
  import tc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_set_i,
  input  logic               wr_clr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] set_v, clr_v;

  assign set_v = wr_set_i ? wdata_i : '0;
  assign clr_v = wr_clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o | set_v) & ~clr_v;
  end
endmodule

// File: rtl/tc_irq_evt.sv
module tc_irq_evt
  import tc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_evctl_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  input  logic [NUM_EVT-1:0] cond_i,
  output logic [NUM_EVT-1:0] evctl_o,
  output logic [NUM_EVT-1:0] evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         evctl_o <= '0;
    else if (wr_evctl_i) evctl_o <= wdata_i;
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_gate
    assign evt_o[e] = cond_i[e] & evctl_o[e];
  end
endmodule

// File: rtl/tc_irq_unit.sv
module tc_irq_unit
  import tc_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        cond_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              evt_wrap_o,
  output logic              evt_match_o
);
  logic [NUM_SRC-1:0] flags_q, mask_q;
  logic [NUM_EVT-1:0] evctl_q, evt_v;
  logic wr_evctl, wr_set, wr_clr, wr_flag;

  tc_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .we_i(we_i), .addr_i(addr_i), .flags_i(flags_q), .mask_i(mask_q),
    .evctl_i(evctl_q), .wr_evctl_o(wr_evctl), .wr_set_o(wr_set),
    .wr_clr_o(wr_clr), .wr_flag_o(wr_flag), .rdata_o(rdata_o)
  );

  tc_irq_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i), .wr_flag_i(wr_flag),
    .wdata_i(wdata_i[NUM_SRC-1:0]), .flags_o(flags_q)
  );

  tc_irq_mask u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_set_i(wr_set), .wr_clr_i(wr_clr),
    .wdata_i(wdata_i[NUM_SRC-1:0]), .mask_o(mask_q)
  );

  tc_irq_evt u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_evctl_i(wr_evctl),
    .wdata_i(wdata_i[NUM_EVT-1:0]), .cond_i(cond_i[NUM_EVT-1:0]),
    .evctl_o(evctl_q), .evt_o(evt_v)
  );

  assign irq_o       = |(flags_q & mask_q);
  assign evt_wrap_o  = evt_v[SRC_WRAP];
  assign evt_match_o = evt_v[SRC_MTCH];
endmodule

// File: rtl/tc_irq_unit_chk.sv
module tc_irq_unit_chk
  import tc_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        cond_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              evt_wrap_o,
  input logic              evt_match_o,
  input logic [3:0]        flags,
  input logic [3:0]        mask
);
  // R2
  cond_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |cond_i |=> ((flags & $past(cond_i)) == $past(cond_i)));

  // R3
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(A_FLAGS)) |=>
      ((flags & $past(wdata_i[3:0]) & ~$past(cond_i)) == 4'b0));

  // R5
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(A_ENSET)) |=>
      ((mask & $past(wdata_i[3:0])) == $past(wdata_i[3:0])));

  // R6
  mask_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(A_ENCLR)) |=> ((mask & $past(wdata_i[3:0])) == 4'b0));

  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(we_i));

  // R10
  evt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_wrap_o |-> cond_i[0]);

  // R10
  evt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_match_o |-> cond_i[1]);
endmodule

bind tc_irq_unit tc_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .evt_wrap_o(evt_wrap_o), .evt_match_o(evt_match_o),
  .flags(flags_q), .mask(mask_q)
);

// File: tb/tc_irq_unit_test.sv
module tc_irq_unit_test;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [3:0]    cond = 0;
  logic          we = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rdata;
  logic irq, evw, evm;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tc_irq_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .evt_wrap_o(evw), .evt_match_o(evm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(negedge clk); addr = AW'(a); #1;
    check(rdata == DW'(exp), req, int'(rdata), exp);
  endtask

  task automatic pulse(input logic [3:0] v);
    @(negedge clk); cond = v;
    @(negedge clk); cond = 0;
  endtask

  task automatic t_reset();
    rd_chk(3, 0, "R1 flags");
    rd_chk(2, 0, "R1 mask");
    rd_chk(0, 0, "R1 evctl");
    check(!irq && !evw && !evm, "R1 outputs", {irq, evw, evm}, 0);
  endtask

  task automatic t_flag_set();
    pulse(4'b0100);
    rd_chk(3, 4'b0100, "R2 capture error flag");
    pulse(4'b1001);
    rd_chk(3, 4'b1101, "R2 wrap+sync flags sticky");
    check(!irq, "R9 no irq while masked", irq, 0);
  endtask

  task automatic t_flag_clear();
    wr(3, 8'hF0);
    rd_chk(3, 4'b1101, "R3 zero bits keep flags");
    wr(3, 4'b0101);
    rd_chk(3, 4'b1000, "R3 clear selected flags");
    wr(3, 4'b1000);
    rd_chk(3, 0, "R3 all clear");
  endtask

  task automatic t_collision();
    @(negedge clk); cond = 4'b0010; we = 1; addr = 3; wdata = 4'b0010;
    @(negedge clk); cond = 0; we = 0; wdata = 0;
    rd_chk(3, 4'b0010, "R4 set wins over clear");
    wr(3, 4'b0010);
    rd_chk(3, 0, "R4 cleanup");
  endtask

  task automatic t_mask();
    wr(2, 4'b1010);
    rd_chk(2, 4'b1010, "R5 set bits");
    rd_chk(1, 4'b1010, "R7 clear addr reads mask");
    wr(2, 0);
    rd_chk(2, 4'b1010, "R5 zero write no effect");
    wr(1, 0);
    rd_chk(1, 4'b1010, "R6 zero write no effect");
    wr(2, 4'b0001);
    rd_chk(1, 4'b1011, "R5 accumulate");
    wr(1, 4'b0011);
    rd_chk(2, 4'b1000, "R6 clear bits");
    wr(1, 4'b1111);
    rd_chk(2, 0, "R6 clear all");
  endtask

  task automatic t_irq();
    pulse(4'b0001);
    check(!irq, "R8 masked flag no irq", irq, 0);
    wr(2, 4'b0001);
    #1 check(irq, "R9 enable pending flag raises irq", irq, 1);
    repeat (3) @(negedge clk);
    check(irq, "R8 irq persists", irq, 1);
    wr(1, 4'b0001);
    #1 check(!irq, "R8 disable drops irq", irq, 0);
    wr(2, 4'b0001);
    #1 check(irq, "R8 re-enable irq", irq, 1);
    wr(3, 4'b0001);
    #1 check(!irq, "R8 flag clear drops irq", irq, 0);
    wr(2, 4'b1000);
    pulse(4'b0100);
    check(!irq, "R8 other source masked", irq, 0);
    pulse(4'b1000);
    check(irq, "R8 sync source irq", irq, 1);
    wr(3, 4'b1100);
    wr(1, 4'b1111);
    #1 check(!irq, "R8 idle", irq, 0);
  endtask

  task automatic t_events();
    @(negedge clk); cond = 4'b0011; #1;
    check(!evw && !evm, "R10 events gated off", {evw, evm}, 0);
    @(negedge clk); cond = 0;
    wr(0, 4'b0001);
    rd_chk(0, 4'b0001, "R10 evctl readback");
    @(negedge clk); cond = 4'b0011; #1;
    check(evw && !evm, "R10 wrap event only", {evw, evm}, 2);
    @(negedge clk); cond = 0; #1;
    check(!evw, "R10 wrap event is pulse", evw, 0);
    wr(0, 4'b0010);
    @(negedge clk); cond = 4'b0011; #1;
    check(!evw && evm, "R10 match event only", {evw, evm}, 1);
    @(negedge clk); cond = 0;
    wr(3, 4'b1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_flag_set();
    t_flag_clear();
    t_collision();
    t_mask();
    t_irq();
    t_events();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule